// File: doc/BRIEF.md
# FM-Synth Dual Interval Timer

This block provides two 8-bit interval timers behind an index/data host port, the way the timer section of an FM sound generator is reached by software. The host first writes a register number on the index port and then the value on the data port. Three registers exist: a preload for each timer and one shared control register. Each timer counts upward from its preload value on its own tick strobe. When it passes 0xFF it raises its expired flag, reloads its preload and keeps going.

Both tick strobes come from the system clock through one prescaler. The first timer ticks every `PRESCALE` clocks, which is 80 us at the default setting. The second timer ticks every `T2_DIV` first-timer ticks, which is 320 us at the default. The status byte carries the two flags, a summary bit and a fixed device signature. The summary bit also drives the active-high interrupt output, so the host can poll the status byte or wait on the interrupt line.

Top module: `fm_dual_timer`

## Requirements
- R1: A write with `wr_port`=0 selects a register index. A write with `wr_port`=1 stores the value into the selected register. Index 0x02 is the timer-1 preload, 0x03 is the timer-2 preload and 0x04 is the control register. A data write to any other index changes nothing.
- R2: After reset, `status_o` reads 0x06 and `irq_o` is low. Both timers are stopped and unmasked, and both flags are clear.
- R3: Timer 1 advances once every `PRESCALE` clocks. With a preload of 256-N it sets its flag (status bit 6) after N of its ticks.
- R4: Timer 2 advances once every `T2_DIV`*`PRESCALE` clocks. With a preload of 256-N it sets its flag (status bit 5) after N of its ticks.
- R5: The control bits are: bit 0 starts timer 1, bit 1 starts timer 2, bit 6 masks timer 1 and bit 5 masks timer 2. A stopped timer holds its preload value and counts from it again when started.
- R6: A control write with bit 7 set clears both flags. The other bits of that write are not stored.
- R7: A masked timer keeps counting but never sets its flag.
- R8: The status byte is laid out as follows: bit 7 is the summary, bit 6 is the timer-1 flag, bit 5 is the timer-2 flag, and bits 4:0 always read 0b00110.
- R9: The summary bit is the OR of the flags whose timers are currently unmasked, and `irq_o` always equals status bit 7.
- R10: When a running timer overflows, it reloads its preload and keeps counting, so it expires again after the same period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe, one clock per write |
| wr_port | input | 1 | 0 selects the index port, 1 selects the data port |
| wr_data | input | 8 | Host write data |
| status_o | output | 8 | Registered status byte, returned on an index-port read |
| irq_o | output | 1 | Registered active-high interrupt |

## Verification
The assertions check four things on every cycle: the fixed signature bits, that the interrupt matches the summary bit, that a flag rises only after an overflow of its own unmasked timer, and that a flag-reset with both timers masked leaves the status flags at zero. Some behaviour depends on the phase of the free-running prescaler against a host write, so only the bench scenarios can show it. This covers the tick periods of both timers, reload after overflow, that stopped timers restart from the preload, and that ignored indices and the non-stored bits of a reset write have no effect. The bench checks these in windows bounded by the earliest and latest cycle at which a flag can appear.

// File: rtl/fmt_pkg.sv
package fmt_pkg;
  localparam int DW = 8;
  localparam int NT = 2;

  localparam logic [DW-1:0] IDX_PRE1 = 8'h02;
  localparam logic [DW-1:0] IDX_PRE2 = 8'h03;
  localparam logic [DW-1:0] IDX_CTRL = 8'h04;

  localparam int CB_RST    = 7;
  localparam int CB_MASK1  = 6;
  localparam int CB_MASK2  = 5;
  localparam int CB_START2 = 1;
  localparam int CB_START1 = 0;

  localparam logic [4:0] SIG = 5'b00110;

  typedef struct packed {
    logic start;
    logic mask;
  } tmr_ctl_t;
endpackage

// File: rtl/fmt_prescaler.sv
module fmt_prescaler #(
  parameter int PRESCALE = 20000,
  parameter int T2_DIV   = 4
) (
  input  logic       clk,
  input  logic       rst,
  output logic [1:0] tick_o
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam int SW = (T2_DIV > 1) ? $clog2(T2_DIV) : 1;
  localparam logic [PW-1:0] PLAST = PW'(PRESCALE - 1);
  localparam logic [SW-1:0] SLAST = SW'(T2_DIV - 1);

  logic [PW-1:0] pcnt_q;
  logic [SW-1:0] sub_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pcnt_q <= '0;
      sub_q  <= '0;
      tick_o <= '0;
    end else begin
      tick_o <= '0;
      if (pcnt_q == PLAST) begin
        pcnt_q    <= '0;
        tick_o[0] <= 1'b1;
        if (sub_q == SLAST) begin
          sub_q     <= '0;
          tick_o[1] <= 1'b1;
        end else begin
          sub_q <= sub_q + 1'b1;
        end
      end else begin
        pcnt_q <= pcnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/fmt_regs.sv
module fmt_regs
  import fmt_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic                   wr_port,
  input  logic [DW-1:0]          wr_data,
  output logic [NT-1:0][DW-1:0]  preload_o,
  output tmr_ctl_t [NT-1:0]      ctl_o,
  output logic                   flag_clr_o
);
  logic [DW-1:0] idx_q;
  logic          data_wr;
  logic          unused_bits;

  assign data_wr     = wr_en & wr_port;
  assign flag_clr_o  = data_wr && (idx_q == IDX_CTRL) && wr_data[CB_RST];
  assign unused_bits = ^wr_data[4:2];

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q     <= '0;
      preload_o <= '0;
      ctl_o     <= '0;
    end else if (wr_en && !wr_port) begin
      idx_q <= wr_data;
    end else if (data_wr) begin
      case (idx_q)
        IDX_PRE1: preload_o[0] <= wr_data;
        IDX_PRE2: preload_o[1] <= wr_data;
        IDX_CTRL: begin
          if (!wr_data[CB_RST]) begin
            ctl_o[0].start <= wr_data[CB_START1];
            ctl_o[0].mask  <= wr_data[CB_MASK1];
            ctl_o[1].start <= wr_data[CB_START2];
            ctl_o[1].mask  <= wr_data[CB_MASK2];
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/fmt_counter.sv
module fmt_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         start,
  input  logic [W-1:0] preload,
  output logic         ovf_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      ovf_o <= 1'b0;
    end else begin
      ovf_o <= start && tick && (&cnt_q);
      if (!start) begin
        cnt_q <= preload;
      end else if (tick) begin
        if (&cnt_q) cnt_q <= preload;
        else        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/fm_dual_timer.sv
module fm_dual_timer
  import fmt_pkg::*;
#(
  parameter int PRESCALE = 20000,
  parameter int T2_DIV   = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          wr_port,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] status_o,
  output logic          irq_o
);
  logic [1:0]             tick;
  logic [NT-1:0][DW-1:0]  preload;
  tmr_ctl_t [NT-1:0]      ctl;
  logic                   flag_clr;
  logic [NT-1:0]          ovf;
  logic [NT-1:0]          flag_q;
  logic [NT-1:0]          mask_v;
  logic                   summary;

  fmt_prescaler #(.PRESCALE(PRESCALE), .T2_DIV(T2_DIV)) u_pre (
    .clk(clk), .rst(rst), .tick_o(tick)
  );

  fmt_regs u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_port(wr_port), .wr_data(wr_data),
    .preload_o(preload), .ctl_o(ctl), .flag_clr_o(flag_clr)
  );

  for (genvar t = 0; t < NT; t++) begin : g_tmr
    assign mask_v[t] = ctl[t].mask;

    fmt_counter #(.W(DW)) u_cnt (
      .clk(clk), .rst(rst), .tick(tick[t]), .start(ctl[t].start),
      .preload(preload[t]), .ovf_o(ovf[t])
    );

    always_ff @(posedge clk) begin
      if (rst) begin
        flag_q[t] <= 1'b0;
      end else begin
        if (flag_clr)                 flag_q[t] <= 1'b0;
        if (ovf[t] && !ctl[t].mask)   flag_q[t] <= 1'b1;
      end
    end
  end

  assign summary = |(flag_q & ~mask_v);

  always_ff @(posedge clk) begin
    if (rst) begin
      status_o <= {3'b000, SIG};
      irq_o    <= 1'b0;
    end else begin
      status_o <= {summary, flag_q[0], flag_q[1], SIG};
      irq_o    <= summary;
    end
  end
endmodule

// File: rtl/fmt_dual_timer_chk.sv
module fmt_dual_timer_chk (
  input logic       clk,
  input logic       rst,
  input logic [7:0] status_o,
  input logic       irq_o,
  input logic [1:0] flag_q,
  input logic [1:0] ovf,
  input logic [1:0] mask_v,
  input logic       flag_clr
);
  // R8
  sig_bits_chk: assert property (@(posedge clk) disable iff (rst)
    status_o[4:0] == 5'b00110);

  // R9
  irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o == status_o[7]);

  // R7
  flag1_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q[0]) |-> $past(ovf[0] && !mask_v[0]));

  // R7
  flag2_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q[1]) |-> $past(ovf[1] && !mask_v[1]));

  // R6
  clr_masked_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_clr && (&mask_v)) |=> ##1 (status_o[7:5] == 3'b000));
endmodule

bind fm_dual_timer fmt_dual_timer_chk u_chk (
  .clk(clk), .rst(rst), .status_o(status_o), .irq_o(irq_o),
  .flag_q(flag_q), .ovf(ovf), .mask_v(mask_v), .flag_clr(flag_clr)
);

// File: tb/fm_dual_timer_tb.sv
module fm_dual_timer_tb;
  localparam int P = 8;
  localparam int D = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic       wr_port = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] status_o;
  logic       irq_o;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  fm_dual_timer #(.PRESCALE(P), .T2_DIV(D)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_port(wr_port),
    .wr_data(wr_data), .status_o(status_o), .irq_o(irq_o)
  );

  // index, data, wait cycles, expected status
  localparam logic [39:0] VEC [14] = '{
    {8'h04, 8'h60, 16'd2,          8'h06},  // R1 both masked, stopped
    {8'h04, 8'h80, 16'd2,          8'h06},  // R6
    {8'h02, 8'hFF, 16'd2,          8'h06},  // R1
    {8'h04, 8'h21, 16'(P+4),       8'hC6},  // R3 R8 timer 1 expires
    {8'h04, 8'h60, 16'd2,          8'h46},  // R9 mask removes summary
    {8'h04, 8'h80, 16'd2,          8'h06},  // R6
    {8'h03, 8'hFE, 16'd2,          8'h06},  // R1
    {8'h04, 8'h42, 16'(2*D*P+4),   8'hA6},  // R4 timer 2 expires
    {8'h04, 8'h60, 16'd2,          8'h26},  // R9
    {8'h04, 8'h80, 16'd2,          8'h06},  // R6
    {8'h04, 8'h61, 16'(3*P+4),     8'h06},  // R7 masked timer, no flag
    {8'h05, 8'hFF, 16'd2,          8'h06},  // R1 unknown index ignored
    {8'h04, 8'h00, 16'd2,          8'h06},  // R5 stop
    {8'h04, 8'hE3, 16'(3*P+4),     8'h06}   // R6 other bits not stored
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic host_wr(input logic port, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_port = port; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_wr(input logic [7:0] idx, input logic [7:0] val);
    host_wr(1'b0, idx);
    host_wr(1'b1, val);
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R2 status after reset", status_o, 8'h06);
    check("R2 irq after reset", {7'd0, irq_o}, 8'h00);

    for (int i = 0; i < 14; i++) begin
      reg_wr(VEC[i][39:32], VEC[i][31:24]);
      wait_cyc(int'(VEC[i][23:8]));
      check($sformatf("R1/R3-R9 vector %0d", i), status_o, VEC[i][7:0]);
    end

    // R3: period of N=5 ticks for timer 1
    reg_wr(8'h04, 8'h00);
    reg_wr(8'h04, 8'h80);
    reg_wr(8'h02, 8'hFB);
    reg_wr(8'h04, 8'h21);
    wait_cyc(4*P);
    check("R3 timer1 not expired before N ticks", {7'd0, status_o[6]}, 8'h00);
    wait_cyc(P+4);
    check("R3 timer1 expired after N ticks", {7'd0, status_o[6]}, 8'h01);
    check("R9 irq high with unmasked flag", {7'd0, irq_o}, 8'h01);

    // R10: reload after overflow, expires again within one period
    reg_wr(8'h04, 8'h80);
    wait_cyc(5*P+4);
    check("R10 timer1 expires again after reload", {7'd0, status_o[6]}, 8'h01);

    // R5: stop holds preload; restart counts from it again
    reg_wr(8'h04, 8'h60);
    reg_wr(8'h04, 8'h80);
    wait_cyc(2);
    check("R5 stopped and cleared", status_o, 8'h06);
    reg_wr(8'h04, 8'h21);
    wait_cyc(4*P);
    check("R5 restart from preload not early", {7'd0, status_o[6]}, 8'h00);
    wait_cyc(P+4);
    check("R5 restart from preload expires", {7'd0, status_o[6]}, 8'h01);
    reg_wr(8'h04, 8'h60);
    reg_wr(8'h04, 8'h80);

    // R4: timer 2 tick spacing, N=2
    reg_wr(8'h03, 8'hFE);
    reg_wr(8'h04, 8'h42);
    wait_cyc(D*P);
    check("R4 timer2 not expired before N ticks", {7'd0, status_o[5]}, 8'h00);
    wait_cyc(D*P+4);
    check("R4 timer2 expired after N ticks", {7'd0, status_o[5]}, 8'h01);
    check("R9 irq from timer2", {7'd0, irq_o}, 8'h01);

    // R9: masking the expired timer drops irq but keeps its flag
    reg_wr(8'h04, 8'h62);
    wait_cyc(2);
    check("R9 irq low once masked", {7'd0, irq_o}, 8'h00);
    check("R9 flag kept under mask", status_o, 8'h26);

    // R6: reset command clears the flag
    reg_wr(8'h04, 8'h60);
    reg_wr(8'h04, 8'h80);
    wait_cyc(2);
    check("R6 flags cleared", status_o, 8'h06);

    // R2: reset again mid-run returns to idle
    reg_wr(8'h04, 8'h21);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    wait_cyc(P+4);
    check("R2 reset stops timers", status_o, 8'h06);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule